// File: doc/BRIEF.md
# Sampled-Update Hashed Stream Index

This controller keeps a shared index that maps a physical miss address to a pointer into one core's miss-history log. The index is stored in external memory as hash buckets. Each bucket is one memory line that holds a small set of entries, and each entry carries a valid bit, an address tag, the owning core and the log pointer. Replacement inside a bucket follows least-recently-used order.

Two kinds of request arrive on one port. A lookup hashes the trigger address and reads the bucket line once. It then reports hit or miss, together with the core and pointer of the matching entry. An update carries an address, a core and a pointer. Before it touches memory, it must win a biased coin flip drawn from a linear feedback shift register and compared against a programmable threshold. Because of this, index write traffic scales with the chosen probability.

Every request that is processed is a read-modify-write of one bucket. All metadata traffic is marked low priority. The controller takes no new request until the write-back has been issued.

Top module: `hidx_ctrl`

## Requirements
- R1: The bucket index is address bits [IDX_W-1:0] XOR address bits [2*IDX_W-1:IDX_W]. The tag is address bits [ADDR_W-1:IDX_W]. The bucket read is issued to memory line address equal to that index.
- R2: A lookup issues one line read. It returns a one-cycle response with hit=1 and the stored core and pointer of the valid entry whose tag matches, or hit=0 when no entry matches. A lookup miss writes nothing back.
- R3: An update whose tag is already present in the bucket replaces that entry's core and pointer. It allocates no other way, so no other entry of the bucket is displaced.
- R4: An update whose tag is absent fills an invalid way if one exists. When all ways are valid, it replaces the least-recently-used entry.
- R5: A lookup hit or an update makes the touched entry most-recently-used. Entries that were more recent than it each age by one step.
- R6: On a lookup hit, the response and the write-back of the promoted bucket line are presented in the same cycle.
- R7: Each accepted update advances a 16-bit LFSR (taps x^16+x^14+x^13+x^11, nonzero seed). The update is applied only if the current LFSR value is at most the threshold input. A threshold of 0 never applies an update and 0xFFFF always does. A rejected update causes no memory request and no busy cycle, and a later lookup of its address misses.
- R8: The fraction of updates applied follows threshold/65535. A threshold of 8192 applies about one update in eight.
- R9: From the acceptance of a lookup or a winning update until its final memory handshake or response, the request-ready output is low.
- R10: Every memory request carries the low-priority flag. A request stalled by the memory holds its valid, address and write-enable.
- R11: After reset the controller is ready, with no response and no memory request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thresh_i | input | LFSR_W | Sampling threshold for updates |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_is_upd_i | input | 1 | 1 = update, 0 = lookup |
| req_addr_i | input | ADDR_W | Miss block address |
| req_core_i | input | CORE_W | Core owning the pointer (update) |
| req_ptr_i | input | PTR_W | History log pointer (update) |
| rsp_valid_o | output | 1 | Lookup result valid, one cycle |
| rsp_hit_o | output | 1 | Lookup found the address |
| rsp_core_o | output | CORE_W | Core of the found entry |
| rsp_ptr_o | output | PTR_W | Pointer of the found entry |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_we_o | output | 1 | 1 = line write, 0 = line read |
| mem_req_lowpri_o | output | 1 | Low-priority marker |
| mem_req_addr_o | output | IDX_W | Bucket line address |
| mem_req_wdata_o | output | LINE_W | Write data line |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | LINE_W | Read data line |

## Verification
A lookup hit produces its response and the write-back that promotes the entry in the same cycle. The bench provokes this case with repeated hits on a bucket shared by five colliding addresses. At the response cycle it checks that a write request is also on the memory port, and that no write appears for a miss. The LRU effect of that shared write-back is then judged indirectly: later updates evict exactly the entry that the hit sequence left oldest. Later lookups confirm which entries survived.

// File: rtl/hidx_pkg.sv
package hidx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RWAIT,
    ST_WR,
    ST_RSP
  } hidx_state_e;
endpackage

// File: rtl/hidx_hash.sv
module hidx_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  // fold next slice into low bits; tag keeps everything above the index
  assign idx_o = addr_i[IDX_W-1:0] ^ addr_i[2*IDX_W-1:IDX_W];
  assign tag_o = addr_i[ADDR_W-1:IDX_W];
endmodule

// File: rtl/hidx_sampler.sv
module hidx_sampler #(
  parameter int           LFSR_W = 16,
  parameter logic [15:0]  TAPS   = 16'hB400,
  parameter logic [15:0]  SEED   = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [LFSR_W-1:0] thresh_i,
  output logic              win_o
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;

  assign fb    = ^(lfsr_q & LFSR_W'(TAPS));
  assign win_o = (lfsr_q <= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= LFSR_W'(SEED);
    else if (step_i) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R7
  AST_LFSR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> lfsr_q != $past(lfsr_q)); // R8
endmodule

// File: rtl/hidx_bucket.sv
module hidx_bucket #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int CORE_W = 2,
  parameter int PTR_W  = 20,
  parameter int WAYS   = 4,
  parameter int LINE_W = 512,
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int RANK_W = $clog2(WAYS),
  localparam int ENT_W  = 1 + TAG_W + CORE_W + PTR_W + RANK_W
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              is_upd_i,
  input  logic [CORE_W-1:0] core_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [WAYS-1:0]   match_o,
  output logic              hit_o,
  output logic [CORE_W-1:0] hit_core_o,
  output logic [PTR_W-1:0]  hit_ptr_o,
  output logic [LINE_W-1:0] line_o
);
  localparam int RANK_LSB = 0;
  localparam int PTR_LSB  = RANK_LSB + RANK_W;
  localparam int CORE_LSB = PTR_LSB + PTR_W;
  localparam int TAG_LSB  = CORE_LSB + CORE_W;
  localparam int VLD_BIT  = TAG_LSB + TAG_W;

  logic [WAYS-1:0]   vld;
  logic [TAG_W-1:0]  tag  [WAYS];
  logic [CORE_W-1:0] core [WAYS];
  logic [PTR_W-1:0]  ptr  [WAYS];
  logic [RANK_W-1:0] rank [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_unpack
    logic [ENT_W-1:0] ent;
    assign ent         = line_i[g*ENT_W +: ENT_W];
    assign vld[g]      = ent[VLD_BIT];
    assign tag[g]      = ent[TAG_LSB +: TAG_W];
    assign core[g]     = ent[CORE_LSB +: CORE_W];
    assign ptr[g]      = ent[PTR_LSB +: PTR_W];
    assign rank[g]     = ent[RANK_LSB +: RANK_W];
    assign match_o[g]  = vld[g] && (tag[g] == tag_i);
  end

  logic [RANK_W-1:0] hit_way, free_way, vict_way, tgt_way, old_rank;
  logic              has_free;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    vict_way = '0;
    has_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_o[w]) hit_way = RANK_W'(w);
      if (!vld[w]) begin
        free_way = RANK_W'(w);
        has_free = 1'b1;
      end
      if (vld[w] && rank[w] == RANK_W'(WAYS - 1)) vict_way = RANK_W'(w);
    end
  end

  assign hit_o      = |match_o;
  assign hit_core_o = core[hit_way];
  assign hit_ptr_o  = ptr[hit_way];
  assign tgt_way    = hit_o ? hit_way : (has_free ? free_way : vict_way);
  assign old_rank   = hit_o ? rank[hit_way] : RANK_W'(WAYS - 1);

  always_comb begin
    line_o = line_i;
    for (int w = 0; w < WAYS; w++) begin
      if (RANK_W'(w) == tgt_way) begin
        if (is_upd_i)
          line_o[w*ENT_W +: ENT_W] = {1'b1, tag_i, core_i, ptr_i, {RANK_W{1'b0}}};
        else
          line_o[w*ENT_W +: ENT_W] = {vld[w], tag[w], core[w], ptr[w], {RANK_W{1'b0}}};
      end else if (vld[w] && rank[w] < old_rank) begin
        line_o[w*ENT_W + RANK_LSB +: RANK_W] = rank[w] + RANK_W'(1);
      end
    end
  end
endmodule

// File: rtl/hidx_ctrl.sv
module hidx_ctrl
  import hidx_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          IDX_W     = 8,
  parameter int          CORE_W    = 2,
  parameter int          PTR_W     = 20,
  parameter int          WAYS      = 4,
  parameter int          LINE_W    = 512,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LFSR_W-1:0] thresh_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_is_upd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic [PTR_W-1:0]  req_ptr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [CORE_W-1:0] rsp_core_o,
  output logic [PTR_W-1:0]  rsp_ptr_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic              mem_req_lowpri_o,
  output logic [IDX_W-1:0]  mem_req_addr_o,
  output logic [LINE_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [LINE_W-1:0] mem_rsp_rdata_i
);
  hidx_state_e state_q;

  logic [IDX_W-1:0]  h_idx, idx_q;
  logic [TAG_W-1:0]  h_tag, tag_q;
  logic [CORE_W-1:0] core_q, hcore_q, b_core;
  logic [PTR_W-1:0]  ptr_q, hptr_q, b_ptr;
  logic              upd_q, hit_q, first_q, b_hit, win;
  logic [WAYS-1:0]   b_match;
  logic [LINE_W-1:0] line_q, b_line;
  logic              fire, upd_step, take;

  hidx_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr_i(req_addr_i), .idx_o(h_idx), .tag_o(h_tag)
  );

  hidx_sampler #(.LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(upd_step),
    .thresh_i(thresh_i), .win_o(win)
  );

  hidx_bucket #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CORE_W(CORE_W), .PTR_W(PTR_W),
    .WAYS(WAYS), .LINE_W(LINE_W)
  ) u_bkt (
    .line_i(mem_rsp_rdata_i), .tag_i(tag_q), .is_upd_i(upd_q),
    .core_i(core_q), .ptr_i(ptr_q), .match_o(b_match), .hit_o(b_hit),
    .hit_core_o(b_core), .hit_ptr_o(b_ptr), .line_o(b_line)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign fire        = req_valid_i && req_ready_o;
  assign upd_step    = fire && req_is_upd_i;
  // losing updates are consumed in IDLE without touching memory
  assign take        = fire && (!req_is_upd_i || win);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tag_q   <= '0;
      core_q  <= '0;
      ptr_q   <= '0;
      upd_q   <= 1'b0;
      hit_q   <= 1'b0;
      hcore_q <= '0;
      hptr_q  <= '0;
      first_q <= 1'b0;
      line_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          idx_q   <= h_idx;
          tag_q   <= h_tag;
          core_q  <= req_core_i;
          ptr_q   <= req_ptr_i;
          upd_q   <= req_is_upd_i;
          state_q <= ST_RD;
        end
        ST_RD: if (mem_req_ready_i) state_q <= ST_RWAIT;
        ST_RWAIT: if (mem_rsp_valid_i) begin
          line_q  <= b_line;
          hit_q   <= b_hit;
          hcore_q <= b_core;
          hptr_q  <= b_ptr;
          first_q <= 1'b1;
          state_q <= (upd_q || b_hit) ? ST_WR : ST_RSP;
        end
        ST_WR: begin
          first_q <= 1'b0;
          if (mem_req_ready_i) state_q <= ST_IDLE;
        end
        ST_RSP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o  = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_req_we_o     = (state_q == ST_WR);
  assign mem_req_lowpri_o = 1'b1;
  assign mem_req_addr_o   = idx_q;
  assign mem_req_wdata_o  = line_q;

  assign rsp_valid_o = (state_q == ST_RSP) || (state_q == ST_WR && first_q && !upd_q);
  assign rsp_hit_o   = hit_q;
  assign rsp_core_o  = hcore_q;
  assign rsp_ptr_o   = hptr_q;

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_we_o) && $stable(mem_req_addr_o)); // R10
  AST_BUSY_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o); // R9
  AST_HIT_WB_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> mem_req_valid_o && mem_req_we_o); // R6
  AST_MISS_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> !mem_req_valid_o); // R2
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R2
  AST_TAG_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RWAIT) && mem_rsp_valid_i |-> $onehot0(b_match)); // R3
endmodule

// File: tb/hidx_ctrl_tb.sv
module hidx_ctrl_tb_top;
  localparam int AW = 32, IW = 8, CW = 2, PW = 20, LW = 512, NB = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [15:0]   thresh;
  logic          req_valid = 1'b0, req_upd = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_core = '0;
  logic [PW-1:0] req_ptr = '0;
  logic          req_ready, rsp_valid, rsp_hit;
  logic [CW-1:0] rsp_core;
  logic [PW-1:0] rsp_ptr;
  logic          m_valid, m_we, m_lowpri;
  logic          m_ready = 1'b0, m_rvalid = 1'b0;
  logic [IW-1:0] m_addr;
  logic [LW-1:0] m_wdata, m_rdata = '0;

  hidx_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .thresh_i(thresh),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_is_upd_i(req_upd),
    .req_addr_i(req_addr), .req_core_i(req_core), .req_ptr_i(req_ptr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_core_o(rsp_core), .rsp_ptr_o(rsp_ptr),
    .mem_req_valid_o(m_valid), .mem_req_ready_i(m_ready), .mem_req_we_o(m_we),
    .mem_req_lowpri_o(m_lowpri), .mem_req_addr_o(m_addr), .mem_req_wdata_o(m_wdata),
    .mem_rsp_valid_i(m_rvalid), .mem_rsp_rdata_i(m_rdata)
  );

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, lowpri_bad = 0, hold_bad = 0, cyc = 0, pend = 0;
  logic [IW-1:0] last_rd = '0, pend_addr = '0;
  logic          prev_stall = 1'b0, prev_we = 1'b0;
  logic [IW-1:0] prev_addr = '0;
  logic [LW-1:0] mem [NB];

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: all bench-side activity at negedge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_stall && (!m_valid || m_we != prev_we || m_addr != prev_addr)) hold_bad++;
      m_rvalid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          m_rvalid = 1'b1;
          m_rdata  = mem[pend_addr];
        end
      end
      m_ready = (cyc % 3) != 0;
      prev_stall = m_valid && !m_ready;
      prev_we    = m_we;
      prev_addr  = m_addr;
      if (m_valid && !m_lowpri) lowpri_bad++;
      if (m_valid && m_ready) begin
        if (m_we) begin
          mem[m_addr] = m_wdata;
          wr_cnt++;
        end else begin
          rd_cnt++;
          last_rd   = m_addr;
          pend_addr = m_addr;
          pend      = 2;
        end
      end
    end
  end

  task automatic do_op(input logic upd, input logic [AW-1:0] a, input logic [CW-1:0] c,
                       input logic [PW-1:0] p, output logic h, output logic [CW-1:0] oc,
                       output logic [PW-1:0] op, output logic wb_same, output logic busy);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_upd = upd; req_addr = a; req_core = c; req_ptr = p;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = !req_ready;
    h = 1'b0; oc = '0; op = '0; wb_same = 1'b0;
    if (!upd) begin
      n = 0;
      while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
      h = rsp_hit; oc = rsp_core; op = rsp_ptr; wb_same = m_valid && m_we;
    end
    while (!req_ready) @(negedge clk);
  endtask

  typedef struct packed {
    logic          upd;
    logic [AW-1:0] addr;
    logic [CW-1:0] core;
    logic [PW-1:0] ptr;
    logic          ehit;
    logic [CW-1:0] ecore;
    logic [PW-1:0] eptr;
  } vec_t;

  // five addresses colliding in bucket 5 (mid slice zero)
  localparam logic [AW-1:0] A1 = 32'h0001_0005, A2 = 32'h0002_0005, A3 = 32'h0003_0005,
                            A4 = 32'h0004_0005, A5 = 32'h0005_0005;
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A1, 2'd0, 20'h0,     1'b0, 2'd0, 20'h0},      // R2 empty miss
    '{1'b1, A1, 2'd1, 20'h00111, 1'b0, 2'd0, 20'h0},
    '{1'b0, A1, 2'd0, 20'h0,     1'b1, 2'd1, 20'h00111},  // R2 hit
    '{1'b1, A2, 2'd0, 20'h00222, 1'b0, 2'd0, 20'h0},      // R4 free way
    '{1'b1, A3, 2'd2, 20'h00333, 1'b0, 2'd0, 20'h0},
    '{1'b1, A4, 2'd3, 20'h00444, 1'b0, 2'd0, 20'h0},
    '{1'b0, A1, 2'd0, 20'h0,     1'b1, 2'd1, 20'h00111},  // R5 promote A1
    '{1'b1, A5, 2'd1, 20'h00555, 1'b0, 2'd0, 20'h0},      // R4 evict A2
    '{1'b0, A2, 2'd0, 20'h0,     1'b0, 2'd0, 20'h0},      // R4 A2 gone
    '{1'b0, A5, 2'd0, 20'h0,     1'b1, 2'd1, 20'h00555},
    '{1'b0, A3, 2'd0, 20'h0,     1'b1, 2'd2, 20'h00333},
    '{1'b1, A3, 2'd0, 20'h003AA, 1'b0, 2'd0, 20'h0},      // R3 overwrite
    '{1'b0, A3, 2'd0, 20'h0,     1'b1, 2'd0, 20'h003AA},  // R3
    '{1'b0, A4, 2'd0, 20'h0,     1'b1, 2'd3, 20'h00444},  // R3 nothing displaced
    '{1'b0, A1, 2'd0, 20'h0,     1'b1, 2'd1, 20'h00111},
    '{1'b0, A5, 2'd0, 20'h0,     1'b1, 2'd1, 20'h00555},
    '{1'b1, A2, 2'd2, 20'h002BB, 1'b0, 2'd0, 20'h0},      // R5 evicts A3
    '{1'b0, A3, 2'd0, 20'h0,     1'b0, 2'd0, 20'h0},      // R5
    '{1'b0, A2, 2'd0, 20'h0,     1'b1, 2'd2, 20'h002BB},
    '{1'b0, A4, 2'd0, 20'h0,     1'b1, 2'd3, 20'h00444}
  };

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic h, wb, busy;
    logic [CW-1:0] oc;
    logic [PW-1:0] op;
    int r0, w0, wins;
    for (int i = 0; i < NB; i++) mem[i] = '0;
    thresh = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !m_valid, "R11", {req_ready, rsp_valid, m_valid}, 3'b100);

    for (int v = 0; v < NV; v++) begin
      do_op(VEC[v].upd, VEC[v].addr, VEC[v].core, VEC[v].ptr, h, oc, op, wb, busy);
      if (!VEC[v].upd) begin
        chk(h == VEC[v].ehit, "R2 hit", h, VEC[v].ehit);
        if (VEC[v].ehit) begin
          chk({oc, op} == {VEC[v].ecore, VEC[v].eptr}, "R2 data", {oc, op}, {VEC[v].ecore, VEC[v].eptr});
          chk(wb == 1'b1, "R6", wb, 1);
        end else begin
          chk(wb == 1'b0, "R2 no writeback", wb, 0);
        end
        chk(busy == 1'b1, "R9", busy, 1);
        chk(last_rd == IW'(5), "R1 bucket", last_rd, 5);
      end
    end

    // R1: xor fold of mid slice
    do_op(1'b1, 32'h0000_0305, 2'd1, 20'h0ABCD, h, oc, op, wb, busy);
    chk(last_rd == 8'h06, "R1 hash", last_rd, 8'h06);
    do_op(1'b0, 32'h0000_0306, 2'd0, 20'h0, h, oc, op, wb, busy);
    chk(last_rd == 8'h05 && !h, "R1 distinct tag", {last_rd, h}, {8'h05, 1'b0});
    do_op(1'b0, 32'h0000_0305, 2'd0, 20'h0, h, oc, op, wb, busy);
    chk(h && op == 20'h0ABCD, "R1 lookup", op, 20'h0ABCD);

    // R7: threshold zero rejects everything without traffic or busy
    thresh = 16'h0000;
    r0 = rd_cnt;
    for (int i = 0; i < 16; i++) begin
      do_op(1'b1, 32'h0077_0011 + AW'(i << 20), 2'd2, 20'h00777, h, oc, op, wb, busy);
      chk(!busy, "R7 no busy", busy, 0);
    end
    chk(rd_cnt == r0, "R7 no traffic", rd_cnt - r0, 0);
    thresh = 16'hFFFF;
    do_op(1'b0, 32'h0077_0011, 2'd0, 20'h0, h, oc, op, wb, busy);
    chk(!h, "R7 rejected absent", h, 0);
    do_op(1'b1, 32'h0077_0011, 2'd2, 20'h00777, h, oc, op, wb, busy);
    do_op(1'b0, 32'h0077_0011, 2'd0, 20'h0, h, oc, op, wb, busy);
    chk(h && oc == 2'd2 && op == 20'h00777, "R7 full threshold", {oc, op}, {2'd2, 20'h00777});

    // R8: threshold 8192 -> about one in eight
    thresh = 16'd8192;
    r0 = rd_cnt; w0 = wr_cnt;
    for (int i = 0; i < 1000; i++)
      do_op(1'b1, 32'h0100_0000 + AW'(i * 32'h10203), 2'd0, PW'(i), h, oc, op, wb, busy);
    wins = wr_cnt - w0;
    chk(wins >= 80 && wins <= 170, "R8 rate", wins, 125);
    chk(rd_cnt - r0 == wins, "R8 read per write", rd_cnt - r0, wins);

    chk(lowpri_bad == 0, "R10 lowpri", lowpri_bad, 0);
    chk(hold_bad == 0, "R10 hold", hold_bad, 0);
    finish_run();
  end
endmodule